// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the programmable part of a pulse-swallow feedback divider. It runs on the output clock of a dual-modulus prescaler: each rising edge of `clk` is one prescaler output period. The block tells the prescaler which modulus to use for the current period (P+1 or P) and raises a single-cycle pulse once the VCO has gone through N = P·B + A cycles. Two down-counters run in parallel. The swallow counter (A) holds the prescaler at P+1 until it reaches zero. The main counter (B) sets the length of the whole output period. When B expires, both counters reload together.

A new setting (prescaler pair, A, B) is offered with a one-cycle write strobe. The block checks it right away. A legal setting is held aside and takes effect at the next period boundary, so a period is never cut short or stretched. An illegal setting raises a reject flag and is dropped. A power-down input holds both counters at their load values and keeps every output quiet. When it is released, counting starts again from a full period.

Top module: `swallow_divider`

## Requirements
- R1: Between two consecutive `divPulse` cycles there are exactly B prescaler cycles and exactly P·B + A VCO cycles, where each prescaler cycle with `modSel` high counts P+1 and each other cycle counts P. `divPulse` is high only in the last prescaler cycle of a period.
- R2: In each period `modSel` is high for the first A prescaler cycles and low for the remaining B − A cycles. With A = B it is high for the whole period, and with A = 0 it never rises.
- R3: The prescaler pair is encoded 0 → 8/9, 1 → 16/17, 2 → 32/33, 3 → 64/65. `prescMode` shows the code in use, and it changes only at a period boundary or during power-down.
- R4: A write (`cfgWrite` high for one cycle) is legal when 3 ≤ B ≤ 4095 and A ≤ B, with A in 0..63. A legal setting governs every period that starts after the next `divPulse` cycle.
- R5: A write with B < 3 or A > B drives `cfgReject` high in exactly the one cycle after the write, and the periods that follow keep the previous setting.
- R6: While `powerDown` is high, `modSel` and `divPulse` stay low, both counters sit at their load state, and a pending legal setting is applied. Counting the first cycle with `powerDown` low as cycle 1, the first `divPulse` falls in cycle B with N VCO cycles.
- R7: After reset the setting is P = 8, A = 0, B = 16. `divPulse`, `modSel` and `cfgReject` are low, and the first pulse falls in the 16th cycle after reset release (128 VCO cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| powerDown | input | 1 | Hold counters at load state, outputs quiet |
| cfgWrite | input | 1 | One-cycle strobe offering a new setting |
| cfgPresc | input | 2 | Prescaler pair code offered |
| cfgA | input | 6 | Swallow count offered |
| cfgB | input | 12 | Main count offered |
| modSel | output | 1 | 1: prescaler divides by P+1, 0: by P |
| divPulse | output | 1 | One-cycle pulse, last prescaler cycle of each period |
| prescMode | output | 2 | Prescaler pair code in use |
| cfgReject | output | 1 | One-cycle flag after an illegal write |

## Verification
Several properties are checked on every cycle. Two pulses never come back to back. Power-down keeps both outputs low. `modSel` only rises at the start of a period. `prescMode` only moves at a boundary or in power-down. A reject always follows a write. The exact period length in prescaler and VCO cycles, the number of P+1 cycles, deferred application of a legal setting and survival of the old setting after a reject can only be shown by the scenarios, which rebuild the VCO count from `modSel` and `prescMode`.

// File: rtl/swallow_pkg.sv
package swallow_pkg;

  typedef enum logic [1:0] {
    PSC_8  = 2'd0,
    PSC_16 = 2'd1,
    PSC_32 = 2'd2,
    PSC_64 = 2'd3
  } pscSel_t;

  typedef struct packed {
    logic capture;  // legal write: store into pending set
    logic apply;    // pending set becomes active this edge
    logic reload;   // period boundary: counters reload
    logic hold;     // power-down: counters forced to load state
  } swStrobe_t;

endpackage

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
  import swallow_pkg::*;
#(
  parameter int B_W   = 12,
  parameter int A_W   = 6,
  parameter int B_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           powerDown,
  input  logic           cfgWrite,
  input  logic [A_W-1:0] cfgA,
  input  logic [B_W-1:0] cfgB,
  input  logic           bZero,
  output swStrobe_t      strobe,
  output logic           cfgReject
);

  localparam int PAD_W = B_W - A_W;

  logic pendValid;
  logic cfgLegal;
  logic [B_W-1:0] aWide;

  always_comb begin
    aWide    = {{PAD_W{1'b0}}, cfgA};
    cfgLegal = (cfgB >= B_W'(B_MIN)) && (aWide <= cfgB);
  end

  always_comb begin
    strobe.capture = cfgWrite && cfgLegal;
    strobe.hold    = powerDown;
    strobe.reload  = bZero && !powerDown;
    strobe.apply   = pendValid && (powerDown || bZero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendValid <= 1'b0;
      cfgReject <= 1'b0;
    end else begin
      cfgReject <= cfgWrite && !cfgLegal;
      if (strobe.capture)    pendValid <= 1'b1;
      else if (strobe.apply) pendValid <= 1'b0;
    end
  end

endmodule

// File: rtl/swallow_datapath.sv
module swallow_datapath
  import swallow_pkg::*;
#(
  parameter int B_W      = 12,
  parameter int A_W      = 6,
  parameter int DEF_B    = 16,
  parameter int DEF_A    = 0,
  parameter int DEF_PSEL = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           powerDown,
  input  swStrobe_t      strobe,
  input  logic [1:0]     cfgPresc,
  input  logic [A_W-1:0] cfgA,
  input  logic [B_W-1:0] cfgB,
  output logic           bZero,
  output logic           modSel,
  output logic           divPulse,
  output logic [1:0]     prescMode
);

  localparam logic [B_W-1:0] RST_B = B_W'(DEF_B);
  localparam logic [A_W-1:0] RST_A = A_W'(DEF_A);
  localparam pscSel_t        RST_P = pscSel_t'(2'(DEF_PSEL));

  logic [B_W-1:0] actB, pendB, srcB, bCnt;
  logic [A_W-1:0] actA, pendA, srcA, aCnt;
  pscSel_t        actP, pendP;

  always_comb begin
    srcB = strobe.apply ? pendB : actB;
    srcA = strobe.apply ? pendA : actA;
  end

  // setting registers: pending (written) and active (in use)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendB <= RST_B;
      pendA <= RST_A;
      pendP <= RST_P;
      actB  <= RST_B;
      actA  <= RST_A;
      actP  <= RST_P;
    end else begin
      if (strobe.capture) begin
        pendB <= cfgB;
        pendA <= cfgA;
        pendP <= pscSel_t'(cfgPresc);
      end
      if (strobe.apply) begin
        actB <= pendB;
        actA <= pendA;
        actP <= pendP;
      end
    end
  end

  // main and swallow counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bCnt <= RST_B - 1'b1;
      aCnt <= RST_A;
    end else if (strobe.hold || strobe.reload) begin
      bCnt <= srcB - 1'b1;
      aCnt <= srcA;
    end else begin
      bCnt <= bCnt - 1'b1;
      if (aCnt != '0) aCnt <= aCnt - 1'b1;
    end
  end

  always_comb begin
    bZero     = (bCnt == '0);
    divPulse  = bZero && !powerDown;
    modSel    = (aCnt != '0) && !powerDown;
    prescMode = actP;
  end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_pkg::*;
#(
  parameter int B_W      = 12,
  parameter int A_W      = 6,
  parameter int B_MIN    = 3,
  parameter int DEF_B    = 16,
  parameter int DEF_A    = 0,
  parameter int DEF_PSEL = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           powerDown,
  input  logic           cfgWrite,
  input  logic [1:0]     cfgPresc,
  input  logic [A_W-1:0] cfgA,
  input  logic [B_W-1:0] cfgB,
  output logic           modSel,
  output logic           divPulse,
  output logic [1:0]     prescMode,
  output logic           cfgReject
);

  swStrobe_t strobe;
  logic      bZero;

  swallow_ctrl #(
    .B_W(B_W), .A_W(A_W), .B_MIN(B_MIN)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .powerDown(powerDown),
    .cfgWrite(cfgWrite), .cfgA(cfgA), .cfgB(cfgB),
    .bZero(bZero), .strobe(strobe), .cfgReject(cfgReject)
  );

  swallow_datapath #(
    .B_W(B_W), .A_W(A_W), .DEF_B(DEF_B), .DEF_A(DEF_A), .DEF_PSEL(DEF_PSEL)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .powerDown(powerDown), .strobe(strobe),
    .cfgPresc(cfgPresc), .cfgA(cfgA), .cfgB(cfgB),
    .bZero(bZero), .modSel(modSel), .divPulse(divPulse), .prescMode(prescMode)
  );

endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       powerDown,
  input logic       cfgWrite,
  input logic       modSel,
  input logic       divPulse,
  input logic [1:0] prescMode,
  input logic       cfgReject
);

  // R1: a period spans at least three prescaler cycles
  a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    divPulse |=> !divPulse);

  // R6: quiet outputs in power-down
  a_r6_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    powerDown |-> (!divPulse && !modSel));

  // R2: swallow phase only begins at a period start
  a_r2_mod_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modSel) |-> $past(divPulse || powerDown));

  // R3: prescaler code changes only at a boundary or in power-down
  a_r3_mode_moves_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prescMode) |-> $past(divPulse || powerDown));

  // R5: a reject always answers a write one cycle earlier
  a_r5_reject_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfgReject |-> $past(cfgWrite));

  // R5: reject lasts one cycle unless another write came
  a_r5_reject_single: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgReject && !cfgWrite) |=> !cfgReject);

endmodule

bind swallow_divider swallow_divider_chk i_swallow_chk (
  .clk(clk), .rst_n(rst_n), .powerDown(powerDown), .cfgWrite(cfgWrite),
  .modSel(modSel), .divPulse(divPulse), .prescMode(prescMode),
  .cfgReject(cfgReject)
);

// File: tb/test_swallow_divider.sv
`timescale 1ns/1ps
module test_swallow_divider;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        powerDown = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [1:0]  cfgPresc = 2'd0;
  logic [5:0]  cfgA = 6'd0;
  logic [11:0] cfgB = 12'd0;
  logic        modSel, divPulse, cfgReject;
  logic [1:0]  prescMode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  swallow_divider i_swallow_divider (
    .clk(clk), .rst_n(rst_n), .powerDown(powerDown), .cfgWrite(cfgWrite),
    .cfgPresc(cfgPresc), .cfgA(cfgA), .cfgB(cfgB), .modSel(modSel),
    .divPulse(divPulse), .prescMode(prescMode), .cfgReject(cfgReject)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pOf(input int code);
    return 8 << code;
  endfunction

  // counts from the cycle under way (just after a negedge) up to the pulse
  task automatic measureFromNow(output int cyc, output int vco, output int mods);
    cyc = 0; vco = 0; mods = 0;
    forever begin
      #1;
      cyc++;
      vco += modSel ? pOf(prescMode) + 1 : pOf(prescMode);
      if (modSel) mods++;
      if (divPulse) break;
      @(negedge clk);
    end
  endtask

  task automatic syncPulse();
    @(negedge clk);
    while (!divPulse) @(negedge clk);
  endtask

  task automatic measureNext(output int cyc, output int vco, output int mods);
    syncPulse();
    @(negedge clk);
    measureFromNow(cyc, vco, mods);
  endtask

  task automatic writeCfg(input int sel, input int a, input int b);
    cfgPresc = 2'(sel); cfgA = 6'(a); cfgB = 12'(b); cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  // writes a legal setting mid-period, then measures the first period using it
  task automatic runSetting(input string req, input int sel, input int a, input int b);
    int cyc, vco, mods;
    syncPulse();
    @(negedge clk);
    writeCfg(sel, a, b);
    measureNext(cyc, vco, mods);
    check(cyc == b, {req, " prescaler cycles"}, cyc, b);
    check(vco == pOf(sel) * b + a, {req, " VCO cycles"}, vco, pOf(sel) * b + a);
    check(mods == a, {req, " P+1 cycles"}, mods, a);
    check(int'(prescMode) == sel, {req, " prescMode"}, prescMode, sel);
  endtask

  task automatic testReset();
    int cyc, vco, mods;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(divPulse == 1'b0, "R7 divPulse in reset", divPulse, 0);
    check(modSel == 1'b0, "R7 modSel in reset", modSel, 0);
    check(cfgReject == 1'b0, "R7 cfgReject in reset", cfgReject, 0);
    check(prescMode == 2'd0, "R7 prescMode in reset", prescMode, 0);
    rst_n = 1'b1;
    measureFromNow(cyc, vco, mods);
    check(cyc == 16, "R7 first period cycles", cyc, 16);
    check(vco == 128, "R7 first period VCO", vco, 128);
  endtask

  task automatic testReject(input int a, input int b, input int keepSel,
                            input int keepA, input int keepB);
    int cyc, vco, mods;
    syncPulse();
    @(negedge clk);
    writeCfg(3, a, b);
    check(cfgReject == 1'b1, "R5 reject raised", cfgReject, 1);
    @(negedge clk);
    check(cfgReject == 1'b0, "R5 reject one cycle", cfgReject, 0);
    measureNext(cyc, vco, mods);
    measureNext(cyc, vco, mods);
    check(cyc == keepB, "R5 old B kept", cyc, keepB);
    check(vco == pOf(keepSel) * keepB + keepA, "R5 old N kept", vco,
          pOf(keepSel) * keepB + keepA);
    check(int'(prescMode) == keepSel, "R5 old prescMode kept", prescMode, keepSel);
  endtask

  task automatic testDeferred();
    int cyc, vco, mods;
    // current setting: sel1 A=3 B=10; new one must not affect the running period
    syncPulse();
    @(negedge clk);
    writeCfg(0, 2, 7);
    measureFromNow(cyc, vco, mods);
    check(cyc == 9, "R4 running period untouched", cyc, 9);
    check(int'(prescMode) == 1, "R4 prescMode untouched", prescMode, 1);
    @(negedge clk);
    measureFromNow(cyc, vco, mods);
    check(vco == 8 * 7 + 2, "R4 new setting after boundary", vco, 58);
  endtask

  task automatic testPowerDown();
    int cyc, vco, mods;
    @(negedge clk);
    @(negedge clk);
    powerDown = 1'b1;
    writeCfg(1, 4, 6);
    for (int k = 0; k < 4; k++) begin
      check(modSel == 1'b0, "R6 modSel low in power-down", modSel, 0);
      check(divPulse == 1'b0, "R6 divPulse low in power-down", divPulse, 0);
      @(negedge clk);
    end
    check(int'(prescMode) == 1, "R6 setting applied in power-down", prescMode, 1);
    powerDown = 1'b0;
    measureFromNow(cyc, vco, mods);
    check(cyc == 6, "R6 full period after release", cyc, 6);
    check(vco == 16 * 6 + 4, "R6 VCO after release", vco, 100);
    check(mods == 4, "R6 P+1 cycles after release", mods, 4);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    runSetting("R1 R2 R3 sel1", 1, 3, 10);
    testDeferred();
    runSetting("R2 A equals B sel3", 3, 5, 5);
    runSetting("R2 A zero sel2", 2, 0, 9);
    runSetting("R4 B minimum", 0, 3, 3);
    testReject(10, 4, 0, 3, 3);
    testReject(0, 2, 0, 3, 3);
    runSetting("R1 R4 B maximum", 2, 63, 4095);
    testPowerDown();
    runSetting("R3 sel0 after power-down", 0, 1, 12);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule